// File: doc/BRIEF.md
# Multi-Lane Serial Command Receiver

This block is the slave-side command front end of a serial flash-style device. It watches a chip-select, a serial clock and a four-bit data bus, and takes the bus one, two or four bits wide per serial clock depending on a lane-mode setting. Each frame opens when chip-select falls and closes when it rises. The block shifts in an eight-bit opcode and recognises two commands. The first writes a byte into one of sixteen per-sector lock registers; its frame carries the opcode, then an address and then the data byte. The second clears the three error bits of a flag status register, and its frame is the opcode alone.

The serial pins are sampled by a fast system clock. A rising serial clock edge is detected after one register stage. Commands only take effect when chip-select rises, so a frame that is cut short leaves no trace. The lock registers and the flag status register can be preset through side ports, and the lock registers are read back through a registered read port. This lets a surrounding model or a testbench place known state around each frame.

Top module: `lane_cmd_rx`

## Requirements
- R1: After reset, flag_status reads 0x00.
- R2: lane_mode selects the bits taken per serial clock. 0 takes one bit on dq[0], 1 takes two bits on dq[1:0], 2 takes four bits on dq[3:0], and 3 behaves as 0. All fields are sent most-significant bit first, and within a clock the highest lane used carries the most significant bit.
- R3: The opcode fills the first 8/L serial clocks of a frame, where L is the number of lanes.
- R4: Opcode LOCK_OP (default 0xE5) is followed by ADDR_W address bits and then 8 data bits. If chip-select rises after at least (16+ADDR_W)/L clocks, the data byte is written to lock entry address[SECT_LSB+3:SECT_LSB]. Further clocks after the data byte are ignored.
- R5: A lock-write frame that ends before its data byte is complete changes no lock entry.
- R6: Opcode CLR_OP (default 0x50) clears flag bits 1 (protection), 4 (program) and 5 (erase) when chip-select rises after at least 8/L clocks. Extra clocks do not cancel it.
- R7: The clear leaves flag bits 0, 2, 3, 6 and 7 unchanged.
- R8: A clear frame that ends before the opcode is complete leaves flag_status unchanged.
- R9: A frame with any other opcode changes neither flag_status nor any lock entry, however many clocks it carries.
- R10: While chip-select is high, serial clock edges are ignored and the frame state is cleared, so the next frame decodes from its first clock.
- R11: preset_flag_we loads flag_status from preset_flag_val. preset_lock_we writes preset_lock_val to entry preset_lock_idx. lock_rd_data returns the entry at lock_rd_idx one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock; data taken on its rising edge |
| spi_cs_n | input | 1 | Active-low chip-select that frames commands |
| spi_dq | input | 4 | Serial data lanes |
| lane_mode | input | 2 | Lanes per clock: 0 one, 1 two, 2 four, 3 one |
| preset_flag_we | input | 1 | Load flag_status from preset_flag_val |
| preset_flag_val | input | 8 | Value for a flag preset |
| preset_lock_we | input | 1 | Write preset_lock_val into a lock entry |
| preset_lock_idx | input | IDX_W (4) | Lock entry selected by a preset |
| preset_lock_val | input | 8 | Value for a lock preset |
| lock_rd_idx | input | IDX_W (4) | Lock entry to read |
| lock_rd_data | output | 8 | Registered lock entry contents |
| flag_status | output | 8 | Flag status register |

## Verification
The assertions check properties on every cycle. A lock write never commits before the full frame length for the current lane mode has been counted, and a clear never commits before the opcode is complete. The cycle counter is always zero after a cycle with chip-select high. Flag bits outside the error mask never move except on a preset, and flag bits only ever fall, one clock after a chip-select rise. Only the bench scenarios can show that the right opcode and address bits are gathered in the right lane order. The bench also shows that aborts at every clock position of every lane mode leave state untouched, and that the correct sector entry receives the correct byte.

// File: rtl/lcr_pkg.sv
package lcr_pkg;

  // frame decode states
  typedef enum logic [2:0] {
    ST_OPCODE,
    ST_ADDR,
    ST_DATA,
    ST_LOCK_ARMED,
    ST_CLR_ARMED,
    ST_DISCARD
  } frame_st_t;

  // flag status bit positions cleared by the clear command
  localparam int FLG_PROT_BIT  = 1;
  localparam int FLG_PROG_BIT  = 4;
  localparam int FLG_ERASE_BIT = 5;
  localparam logic [7:0] FLG_CLR_MASK =
    8'((1 << FLG_PROT_BIT) | (1 << FLG_PROG_BIT) | (1 << FLG_ERASE_BIT));

  // lane mode codes
  localparam logic [1:0] LM_X2 = 2'd1;
  localparam logic [1:0] LM_X4 = 2'd2;

endpackage

// File: rtl/lcr_front.sv
module lcr_front (
  input  logic       clk,
  input  logic       rst,
  input  logic       sclk,
  input  logic       cs_n,
  input  logic [3:0] dq,
  output logic       sclk_rise,
  output logic       cs_high,
  output logic       cs_rise,
  output logic [3:0] dq_s
);

  logic sclk_q, sclk_d, cs_q, cs_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q <= 1'b0;
      sclk_d <= 1'b0;
      cs_q   <= 1'b1;
      cs_d   <= 1'b1;
      dq_s   <= '0;
    end else begin
      sclk_q <= sclk;
      sclk_d <= sclk_q;
      cs_q   <= cs_n;
      cs_d   <= cs_q;
      dq_s   <= dq;
    end
  end

  assign sclk_rise = sclk_q & ~sclk_d & ~cs_q;
  assign cs_high   = cs_q;
  assign cs_rise   = cs_q & ~cs_d;

endmodule

// File: rtl/lcr_shifter.sv
module lcr_shifter #(
  parameter int ADDR_W = 24,
  parameter int CYC_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_clr,
  input  logic              step,
  input  logic [1:0]        lane_mode,
  input  logic [3:0]        dq,
  output logic [CYC_W-1:0]  cyc,
  output logic [ADDR_W-1:0] sh_next
);
  import lcr_pkg::*;

  localparam logic [CYC_W-1:0] CYC_MAX = '1;

  logic [ADDR_W-1:0] sh_q;

  always_comb begin
    unique case (lane_mode)
      LM_X2:   sh_next = {sh_q[ADDR_W-3:0], dq[1:0]};
      LM_X4:   sh_next = {sh_q[ADDR_W-5:0], dq[3:0]};
      default: sh_next = {sh_q[ADDR_W-2:0], dq[0]};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || frame_clr) begin
      cyc  <= '0;
      sh_q <= '0;
    end else if (step) begin
      sh_q <= sh_next;
      if (cyc != CYC_MAX) cyc <= cyc + 1'b1;
    end
  end

endmodule

// File: rtl/lcr_decoder.sv
module lcr_decoder #(
  parameter int         ADDR_W  = 24,
  parameter int         CYC_W   = 7,
  parameter logic [7:0] LOCK_OP = 8'hE5,
  parameter logic [7:0] CLR_OP  = 8'h50
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_clr,
  input  logic              step,
  input  logic              cs_rise,
  input  logic [1:0]        lane_mode,
  input  logic [CYC_W-1:0]  cyc,
  input  logic [ADDR_W-1:0] sh_next,
  output logic              lock_we,
  output logic [ADDR_W-1:0] lock_addr,
  output logic [7:0]        lock_val,
  output logic              clr_we
);
  import lcr_pkg::*;

  // last cycle index of each phase, per lane count
  localparam logic [CYC_W-1:0] OP_END_1 = CYC_W'(7);
  localparam logic [CYC_W-1:0] OP_END_2 = CYC_W'(3);
  localparam logic [CYC_W-1:0] OP_END_4 = CYC_W'(1);
  localparam logic [CYC_W-1:0] AD_END_1 = CYC_W'(7 + ADDR_W);
  localparam logic [CYC_W-1:0] AD_END_2 = CYC_W'(3 + ADDR_W / 2);
  localparam logic [CYC_W-1:0] AD_END_4 = CYC_W'(1 + ADDR_W / 4);
  localparam logic [CYC_W-1:0] DT_END_1 = CYC_W'(15 + ADDR_W);
  localparam logic [CYC_W-1:0] DT_END_2 = CYC_W'(7 + ADDR_W / 2);
  localparam logic [CYC_W-1:0] DT_END_4 = CYC_W'(3 + ADDR_W / 4);

  frame_st_t        st_q;
  logic [CYC_W-1:0] op_end, ad_end, dt_end;

  always_comb begin
    unique case (lane_mode)
      LM_X2: begin
        op_end = OP_END_2; ad_end = AD_END_2; dt_end = DT_END_2;
      end
      LM_X4: begin
        op_end = OP_END_4; ad_end = AD_END_4; dt_end = DT_END_4;
      end
      default: begin
        op_end = OP_END_1; ad_end = AD_END_1; dt_end = DT_END_1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || frame_clr) begin
      st_q <= ST_OPCODE;
    end else if (step) begin
      unique case (st_q)
        ST_OPCODE:
          if (cyc == op_end) begin
            if (sh_next[7:0] == LOCK_OP)     st_q <= ST_ADDR;
            else if (sh_next[7:0] == CLR_OP) st_q <= ST_CLR_ARMED;
            else                             st_q <= ST_DISCARD;
          end
        ST_ADDR:
          if (cyc == ad_end) st_q <= ST_DATA;
        ST_DATA:
          if (cyc == dt_end) st_q <= ST_LOCK_ARMED;
        default: st_q <= st_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_addr <= '0;
      lock_val  <= '0;
    end else if (step) begin
      if (st_q == ST_ADDR && cyc == ad_end) lock_addr <= sh_next;
      if (st_q == ST_DATA && cyc == dt_end) lock_val  <= sh_next[7:0];
    end
  end

  assign lock_we = cs_rise && (st_q == ST_LOCK_ARMED);
  assign clr_we  = cs_rise && (st_q == ST_CLR_ARMED);

endmodule

// File: rtl/lcr_regs.sv
module lcr_regs #(
  parameter int ADDR_W   = 24,
  parameter int SECT_LSB = 16,
  parameter int SECT_CNT = 16,
  parameter int IDX_W    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              preset_flag_we,
  input  logic [7:0]        preset_flag_val,
  input  logic              preset_lock_we,
  input  logic [IDX_W-1:0]  preset_lock_idx,
  input  logic [7:0]        preset_lock_val,
  input  logic              cmd_lock_we,
  input  logic [ADDR_W-1:0] cmd_lock_addr,
  input  logic [7:0]        cmd_lock_val,
  input  logic              cmd_clr_we,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [7:0]        rd_data,
  output logic [7:0]        flags
);
  import lcr_pkg::*;

  logic [7:0]       lock_mem [SECT_CNT];
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [7:0]       wr_val;

  // single write port: preset has priority over a command commit
  always_comb begin
    wr_en  = preset_lock_we | cmd_lock_we;
    wr_idx = preset_lock_we ? preset_lock_idx : cmd_lock_addr[SECT_LSB +: IDX_W];
    wr_val = preset_lock_we ? preset_lock_val : cmd_lock_val;
  end

  always_ff @(posedge clk) begin
    if (wr_en) lock_mem[wr_idx] <= wr_val;
    rd_data <= lock_mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst)                 flags <= '0;
    else if (preset_flag_we) flags <= preset_flag_val;
    else if (cmd_clr_we)     flags <= flags & ~FLG_CLR_MASK;
  end

endmodule

// File: rtl/lane_cmd_rx.sv
module lane_cmd_rx #(
  parameter int         ADDR_W   = 24,
  parameter int         SECT_LSB = 16,
  parameter int         SECT_CNT = 16,
  parameter logic [7:0] LOCK_OP  = 8'hE5,
  parameter logic [7:0] CLR_OP   = 8'h50,
  localparam int        IDX_W    = $clog2(SECT_CNT),
  localparam int        CYC_W    = $clog2(ADDR_W + 17) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             spi_sclk,
  input  logic             spi_cs_n,
  input  logic [3:0]       spi_dq,
  input  logic [1:0]       lane_mode,
  input  logic             preset_flag_we,
  input  logic [7:0]       preset_flag_val,
  input  logic             preset_lock_we,
  input  logic [IDX_W-1:0] preset_lock_idx,
  input  logic [7:0]       preset_lock_val,
  input  logic [IDX_W-1:0] lock_rd_idx,
  output logic [7:0]       lock_rd_data,
  output logic [7:0]       flag_status
);

  logic              sclk_rise, cs_high, cs_rise;
  logic [3:0]        dq_s;
  logic [CYC_W-1:0]  cyc;
  logic [ADDR_W-1:0] sh_next;
  logic              cmd_lock_we, cmd_clr_we;
  logic [ADDR_W-1:0] cmd_lock_addr;
  logic [7:0]        cmd_lock_val;

  lcr_front u_front (
    .clk(clk), .rst(rst), .sclk(spi_sclk), .cs_n(spi_cs_n), .dq(spi_dq),
    .sclk_rise(sclk_rise), .cs_high(cs_high), .cs_rise(cs_rise), .dq_s(dq_s)
  );

  lcr_shifter #(.ADDR_W(ADDR_W), .CYC_W(CYC_W)) u_shift (
    .clk(clk), .rst(rst), .frame_clr(cs_high), .step(sclk_rise),
    .lane_mode(lane_mode), .dq(dq_s), .cyc(cyc), .sh_next(sh_next)
  );

  lcr_decoder #(
    .ADDR_W(ADDR_W), .CYC_W(CYC_W), .LOCK_OP(LOCK_OP), .CLR_OP(CLR_OP)
  ) u_dec (
    .clk(clk), .rst(rst), .frame_clr(cs_high), .step(sclk_rise),
    .cs_rise(cs_rise), .lane_mode(lane_mode), .cyc(cyc), .sh_next(sh_next),
    .lock_we(cmd_lock_we), .lock_addr(cmd_lock_addr), .lock_val(cmd_lock_val),
    .clr_we(cmd_clr_we)
  );

  lcr_regs #(
    .ADDR_W(ADDR_W), .SECT_LSB(SECT_LSB), .SECT_CNT(SECT_CNT), .IDX_W(IDX_W)
  ) u_regs (
    .clk(clk), .rst(rst),
    .preset_flag_we(preset_flag_we), .preset_flag_val(preset_flag_val),
    .preset_lock_we(preset_lock_we), .preset_lock_idx(preset_lock_idx),
    .preset_lock_val(preset_lock_val),
    .cmd_lock_we(cmd_lock_we), .cmd_lock_addr(cmd_lock_addr),
    .cmd_lock_val(cmd_lock_val), .cmd_clr_we(cmd_clr_we),
    .rd_idx(lock_rd_idx), .rd_data(lock_rd_data), .flags(flag_status)
  );

endmodule

// File: rtl/lane_cmd_rx_chk.sv
module lane_cmd_rx_chk #(
  parameter int ADDR_W = 24,
  parameter int CYC_W  = 7
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       lane_mode,
  input logic             preset_flag_we,
  input logic [7:0]       flag_status,
  input logic             cs_rise,
  input logic             cs_high,
  input logic [CYC_W-1:0] cyc,
  input logic             lock_we,
  input logic             clr_we
);
  import lcr_pkg::*;

  logic [CYC_W-1:0] need_frame, need_cmd;

  always_comb begin
    unique case (lane_mode)
      2'd1:    begin need_frame = CYC_W'((ADDR_W + 16) / 2); need_cmd = CYC_W'(4); end
      2'd2:    begin need_frame = CYC_W'((ADDR_W + 16) / 4); need_cmd = CYC_W'(2); end
      default: begin need_frame = CYC_W'(ADDR_W + 16);       need_cmd = CYC_W'(8); end
    endcase
  end

  // R4
  lock_full_frame_chk: assert property (@(posedge clk) disable iff (rst)
    lock_we |-> (cyc >= need_frame));

  // R6
  clr_full_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    clr_we |-> (cyc >= need_cmd));

  // R7
  flag_mask_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(preset_flag_we) |-> (((flag_status ^ $past(flag_status)) & ~FLG_CLR_MASK) == 8'h00));

  // R6
  flag_fall_only_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(preset_flag_we) |-> ((flag_status & ~$past(flag_status)) == 8'h00));

  // R8
  flag_after_csrise_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(preset_flag_we) && (flag_status != $past(flag_status))) |-> $past(cs_rise));

  // R10
  cyc_cleared_chk: assert property (@(posedge clk) disable iff (rst)
    cs_high |=> (cyc == '0));

endmodule

bind lane_cmd_rx lane_cmd_rx_chk #(.ADDR_W(ADDR_W), .CYC_W(CYC_W)) u_chk (
  .clk(clk), .rst(rst), .lane_mode(lane_mode), .preset_flag_we(preset_flag_we),
  .flag_status(flag_status), .cs_rise(cs_rise), .cs_high(cs_high), .cyc(cyc),
  .lock_we(cmd_lock_we), .clr_we(cmd_clr_we)
);

// File: tb/sim_lane_cmd_rx.sv
module sim_lane_cmd_rx;
  localparam int CLK_PERIOD = 10;
  localparam int AW         = 24;
  localparam int SLSB       = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       spi_sclk = 1'b0;
  logic       spi_cs_n = 1'b1;
  logic [3:0] spi_dq = '0;
  logic [1:0] lane_mode = '0;
  logic       preset_flag_we = 1'b0;
  logic [7:0] preset_flag_val = '0;
  logic       preset_lock_we = 1'b0;
  logic [3:0] preset_lock_idx = '0;
  logic [7:0] preset_lock_val = '0;
  logic [3:0] lock_rd_idx = '0;
  logic [7:0] lock_rd_data;
  logic [7:0] flag_status;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  lane_cmd_rx u0 (
    .clk(clk), .rst(rst), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_dq(spi_dq), .lane_mode(lane_mode),
    .preset_flag_we(preset_flag_we), .preset_flag_val(preset_flag_val),
    .preset_lock_we(preset_lock_we), .preset_lock_idx(preset_lock_idx),
    .preset_lock_val(preset_lock_val), .lock_rd_idx(lock_rd_idx),
    .lock_rd_data(lock_rd_data), .flag_status(flag_status)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic int lanes_for(input int mode);
    return (mode == 1) ? 2 : (mode == 2) ? 4 : 1;
  endfunction

  // drive one frame of ncyc serial clocks, then raise chip-select
  task automatic frame(input logic [7:0] op, input logic [AW-1:0] addr,
                       input logic [7:0] data, input int mode, input int ncyc);
    logic [AW+15:0] bits;
    int bpc;
    bits = {op, addr, data};
    bpc  = lanes_for(mode);
    lane_mode = 2'(mode);
    spi_cs_n  = 1'b0;
    tick(4);
    for (int c = 0; c < ncyc; c++) begin
      spi_dq = '0;
      for (int j = 0; j < bpc; j++) begin
        int pos;
        pos = AW + 15 - c * bpc - (bpc - 1 - j);
        if (pos >= 0) spi_dq[j] = bits[pos];
      end
      spi_sclk = 1'b0; tick(4);
      spi_sclk = 1'b1; tick(4);
    end
    spi_sclk = 1'b0; tick(4);
    spi_cs_n = 1'b1;
    tick(8);
  endtask

  task automatic put_lock(input int idx, input logic [7:0] v);
    preset_lock_idx = 4'(idx); preset_lock_val = v; preset_lock_we = 1'b1;
    tick(1);
    preset_lock_we = 1'b0;
  endtask

  task automatic put_flags(input logic [7:0] v);
    preset_flag_val = v; preset_flag_we = 1'b1;
    tick(1);
    preset_flag_we = 1'b0;
  endtask

  task automatic get_lock(input int idx, output logic [7:0] v);
    lock_rd_idx = 4'(idx);
    tick(3);
    v = lock_rd_data;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    tick(4);
    rst = 1'b0;
    tick(2);
    check("R1 reset flags", flag_status, 8'h00);

    // R11: presets and read port
    put_flags(8'hA6);
    tick(1);
    check("R11 flag preset", flag_status, 8'hA6);
    for (int i = 0; i < 16; i++) put_lock(i, 8'(i * 17 + 1));
    for (int i = 0; i < 16; i++) begin
      get_lock(i, rd);
      check("R11 lock preset readback", rd, 8'(i * 17 + 1));
    end

    // R4 R5 R2: lock-write sweep over every abort point in every lane mode
    for (int mode = 0; mode < 4; mode++) begin
      int full;
      full = (AW + 16) / lanes_for(mode);
      for (int k = 0; k <= full + 2; k++) begin
        int sec;
        logic [7:0] dat;
        logic [AW-1:0] adr;
        sec = (k * 5 + mode) % 16;
        dat = 8'(k * 29 + mode * 71 + 3);
        adr = (AW'(sec) << SLSB) | AW'((k * 1237) & 16'hFFFF) | (AW'(k & 15) << 20);
        put_lock(sec, ~dat);
        frame(8'hE5, adr, dat, mode, k);
        get_lock(sec, rd);
        if (k >= full) check(mode == 3 ? "R2 mode3 lock write" : "R4 lock write", rd, dat);
        else           check("R5 aborted lock write", rd, ~dat);
      end
    end

    // R3 R6 R8: clear sweep over opcode abort points
    for (int mode = 0; mode < 4; mode++) begin
      int cmd;
      cmd = 8 / lanes_for(mode);
      for (int k = 0; k <= cmd + 3; k++) begin
        put_flags(8'hFF);
        frame(8'h50, '0, 8'h00, mode, k);
        if (k >= cmd) check("R6 clear after opcode", flag_status, 8'hCD);
        else          check("R8 clear aborted", flag_status, 8'hFF);
      end
    end

    // R3: opcode bits occupy exactly the first 8/L clocks (0x50 followed by ones)
    for (int mode = 0; mode < 3; mode++) begin
      put_flags(8'hFF);
      frame(8'h50, {AW{1'b1}}, 8'hFF, mode, 8 / lanes_for(mode) + 2);
      check("R3 opcode window", flag_status, 8'hCD);
    end

    // R7: bits outside the error mask survive
    put_flags(8'hCD);
    frame(8'h50, '0, 8'h00, 2, 2);
    check("R7 unmasked bits kept", flag_status, 8'hCD);
    put_flags(8'h32);
    frame(8'h50, '0, 8'h00, 1, 4);
    check("R7 masked bits cleared", flag_status, 8'h00);

    // R9: unknown opcodes
    for (int mode = 0; mode < 3; mode++) begin
      logic [7:0] ops [4];
      ops[0] = 8'hE4; ops[1] = 8'h51; ops[2] = 8'hD0; ops[3] = 8'h05;
      for (int o = 0; o < 4; o++) begin
        put_flags(8'hFF);
        put_lock(3, 8'h3C);
        frame(ops[o], AW'(3) << SLSB, 8'hC3, mode, (AW + 16) / lanes_for(mode) + 1);
        check("R9 unknown op flags", flag_status, 8'hFF);
        get_lock(3, rd);
        check("R9 unknown op lock", rd, 8'h3C);
      end
    end

    // R10: serial clocks with chip-select high are ignored
    put_lock(9, 8'h00);
    spi_dq = 4'hF;
    for (int p = 0; p < 5; p++) begin
      spi_sclk = 1'b1; tick(4);
      spi_sclk = 1'b0; tick(4);
    end
    frame(8'hE5, AW'(9) << SLSB, 8'h96, 0, AW + 16);
    get_lock(9, rd);
    check("R10 idle clocks ignored", rd, 8'h96);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule